// File: doc/BRIEF.md
# Disk Channel Control and Status Register

This block is the host-side control and status register of a disk channel controller. Through one control-write port the host can set or clear a chosen group of enable and flag bits, or reset the controller and then set bits. The same write assigns a 3-bit interrupt priority channel. The whole status word can be read at any time, with no side effects. The block also keeps a latched error word and drives the interrupt request line.

The channel sequencer is not part of this block. It connects through a busy input, a halt event, an attention event and an error-event input that carries an error code. A data-out command is sent to the sequencer only while the channel is idle. If it arrives while the channel is running or active, it is dropped and a busy error is recorded. After a reset-then-set write, a one-cycle pulse tells the sequencer to clear its program counter and its count registers.

The register bit positions are part of the contract. Status bits: [2:0] priority channel, 6 active, 7 run, 8 idle-enable, 9 attention, 10 attention-enable, 11 error flag, 12 data-error-enable, 16 seek request, 17 interrupt request. All other status bits read zero. Control-write bit 17 selects set and bit 16 selects clear. When both are set, the controller is reset first and the set is then applied.

Top module: `chan_csr`

## Requirements
- R1: A synchronous active-high `rst` clears the status word, the error word, `cmd_valid`, `cmd_data` and `ctl_clear` to zero.
- R2: A control write with bit 17 set and bit 16 clear ORs the written bits 12, 11, 10, 8 and 7 into the status word. If written bit 9 is one, it sets seek request (status bit 16) and leaves attention unchanged. No other status bit is set by the write.
- R3: A control write with bit 16 set and bit 17 clear clears each of status bits 12, 11, 10, 9, 8 and 7 whose written bit is one. Seek request is not changed.
- R4: A clear write (bit 16 set, bit 17 clear) whose bit 11 is one zeroes the whole error word.
- R5: A control write with bits 17 and 16 both set first zeroes the status word and the error word, then applies the set of R2. `ctl_clear` is high for exactly the following cycle.
- R6: Every control write copies written bits [2:0] into status bits [2:0].
- R7: Status bit 17 and `irq` are one exactly when (data-error-enable and error) or (attention-enable and attention) or (idle-enable and not run) holds in the updated status word.
- R8: An error event ORs `err_code` into the error word and sets the error flag (status bit 11).
- R9: A data-out command that arrives while status run or active is one is dropped: `cmd_valid` stays low, error word bit 2 is set and the error flag is set.
- R10: A data-out command that arrives while run and active are both zero raises `cmd_valid` for one cycle with `cmd_data` equal to the command, and sets active in the same update.
- R11: Events take effect after the control write of the same cycle. A halt event clears run, an attention event sets attention, and error events set the error flag, even if the write would have done otherwise.
- R12: Outside an accepted command, active takes the value of `chan_busy & ~halt_evt` at each clock. A reset-then-set write forces it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 18 | Control write data |
| stat_rdata | output | 18 | Status word |
| err_word | output | ERR_W | Latched error word |
| irq | output | 1 | Interrupt request |
| dout_we | input | 1 | Data-out command strobe |
| dout_wdata | input | CMD_W | Data-out command word |
| cmd_valid | output | 1 | Command passed to the sequencer |
| cmd_data | output | CMD_W | Last accepted command |
| ctl_clear | output | 1 | Pulse: sequencer clears its PC and count registers |
| chan_busy | input | 1 | Sequencer busy |
| halt_evt | input | 1 | Sequencer halted |
| attn_evt | input | 1 | Drive attention event |
| err_evt | input | 1 | Error event strobe |
| err_code | input | ERR_W | Error bits to OR into the error word |

## Verification
The hardest cases are collisions inside one cycle: a clear write that wipes the error word while a new error or a rejected command adds bits to it, or a set of run in the same cycle as a halt. These cases decide the priority between the write and the events. The random stimulus drives all strobes independently in every cycle, so such overlaps happen often. Directed steps also force a run-set together with a halt, an attention-clear together with an attention event, and two back-to-back data-out commands, where the second must be rejected because the first made the channel active.

// File: rtl/chan_csr_pkg.sv
package chan_csr_pkg;

    localparam int STAT_W     = 18;
    localparam int PI_W       = 3;

    localparam int B_IRQ      = 17;
    localparam int B_SEEKRQ   = 16;
    localparam int B_DERR_EN  = 12;
    localparam int B_ERR      = 11;
    localparam int B_ATTN_EN  = 10;
    localparam int B_ATTN     = 9;
    localparam int B_IDLE_EN  = 8;
    localparam int B_RUN      = 7;
    localparam int B_ACT      = 6;

    localparam int W_SET      = 17;
    localparam int W_CLR      = 16;

    // bits a set write may raise: 12,11,10,8,7
    localparam logic [STAT_W-1:0] SET_MASK = 18'h01D80;
    // bits a clear write may drop: 12..7
    localparam logic [STAT_W-1:0] CLR_MASK = 18'h01F80;

    typedef struct packed {
        logic [STAT_W-1:0] stat_after;
        logic              err_wipe;
        logic              full_reset;
    } wr_res_t;

endpackage

// File: rtl/chan_csr_wdec.sv
module chan_csr_wdec
    import chan_csr_pkg::*;
(
    input  logic [STAT_W-1:0] cur_stat,
    input  logic              we,
    input  logic [STAT_W-1:0] wdata,
    output wr_res_t           res
);

    logic do_set;
    logic do_clr;
    logic both;

    assign do_set = we && wdata[W_SET];
    assign do_clr = we && wdata[W_CLR] && !wdata[W_SET];
    assign both   = we && wdata[W_SET] && wdata[W_CLR];

    always_comb begin
        res.stat_after = cur_stat;
        res.err_wipe   = 1'b0;
        res.full_reset = 1'b0;
        if (both) begin
            res.stat_after = '0;
            res.err_wipe   = 1'b1;
            res.full_reset = 1'b1;
        end
        if (do_set) begin
            res.stat_after = res.stat_after | (wdata & SET_MASK);
            if (wdata[B_ATTN]) begin
                res.stat_after[B_SEEKRQ] = 1'b1;
            end
        end else if (do_clr) begin
            res.stat_after = res.stat_after & ~(wdata & CLR_MASK);
            if (wdata[B_ERR]) begin
                res.err_wipe = 1'b1;
            end
        end
        if (we) begin
            res.stat_after[PI_W-1:0] = wdata[PI_W-1:0];
        end
    end

endmodule

// File: rtl/chan_csr_irq.sv
module chan_csr_irq
    import chan_csr_pkg::*;
#(
    parameter int N_SRC = 3
) (
    input  logic [STAT_W-1:0] stat,
    output logic              req
);

    logic [N_SRC-1:0] src;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            if (g == 0) begin : g_derr
                assign src[g] = stat[B_DERR_EN] & stat[B_ERR];
            end else if (g == 1) begin : g_attn
                assign src[g] = stat[B_ATTN_EN] & stat[B_ATTN];
            end else begin : g_idle
                assign src[g] = stat[B_IDLE_EN] & ~stat[B_RUN];
            end
        end
    endgenerate

    assign req = |src;

endmodule

// File: rtl/chan_csr_errlog.sv
module chan_csr_errlog #(
    parameter int ERR_W        = 12,
    parameter int BUSY_ERR_BIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             evt,
    input  logic [ERR_W-1:0] code,
    input  logic             busy_rej,
    output logic [ERR_W-1:0] err_word
);

    logic [ERR_W-1:0] err_d;
    logic [ERR_W-1:0] err_q;

    always_comb begin
        err_d = err_q;
        if (wipe) begin
            err_d = '0;
        end
        if (evt) begin
            err_d = err_d | code;
        end
        if (busy_rej) begin
            err_d[BUSY_ERR_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_word = err_q;

    // R8
    err_accum_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> ((err_word & $past(code)) == $past(code)));

    // R4
    err_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (wipe && !evt && !busy_rej) |=> (err_word == '0));

    // R9
    busy_code_chk: assert property (@(posedge clk) disable iff (rst)
        busy_rej |=> err_word[BUSY_ERR_BIT]);

endmodule

// File: rtl/chan_csr.sv
module chan_csr
    import chan_csr_pkg::*;
#(
    parameter int ERR_W        = 12,
    parameter int CMD_W        = 36,
    parameter int BUSY_ERR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [17:0]       ctl_wdata,
    output logic [17:0]       stat_rdata,
    output logic [ERR_W-1:0]  err_word,
    output logic              irq,
    input  logic              dout_we,
    input  logic [CMD_W-1:0]  dout_wdata,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              ctl_clear,
    input  logic              chan_busy,
    input  logic              halt_evt,
    input  logic              attn_evt,
    input  logic              err_evt,
    input  logic [ERR_W-1:0]  err_code
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              cmd_v;
        logic [CMD_W-1:0]  cmd_d;
        logic              clr;
    } regs_t;

    regs_t             r_d;
    regs_t             r_q;
    wr_res_t           wres;
    logic [STAT_W-1:0] st_mid;
    logic              busy_now;
    logic              accept;
    logic              reject;
    logic              irq_d;

    assign busy_now = r_q.stat[B_RUN] | r_q.stat[B_ACT];
    assign accept   = dout_we & ~busy_now;
    assign reject   = dout_we & busy_now;

    chan_csr_wdec u_wdec (
        .cur_stat (r_q.stat),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .res      (wres)
    );

    // events are layered on top of the write result
    always_comb begin
        st_mid         = wres.stat_after;
        st_mid[B_ACT]  = accept | (~wres.full_reset & chan_busy & ~halt_evt);
        if (halt_evt) begin
            st_mid[B_RUN] = 1'b0;
        end
        if (attn_evt) begin
            st_mid[B_ATTN] = 1'b1;
        end
        if (err_evt || reject) begin
            st_mid[B_ERR] = 1'b1;
        end
    end

    chan_csr_irq #(.N_SRC(3)) u_irq (
        .stat (st_mid),
        .req  (irq_d)
    );

    chan_csr_errlog #(
        .ERR_W        (ERR_W),
        .BUSY_ERR_BIT (BUSY_ERR_BIT)
    ) u_errlog (
        .clk      (clk),
        .rst      (rst),
        .wipe     (wres.err_wipe),
        .evt      (err_evt),
        .code     (err_code),
        .busy_rej (reject),
        .err_word (err_word)
    );

    always_comb begin
        r_d              = r_q;
        r_d.stat         = st_mid;
        r_d.stat[B_IRQ]  = irq_d;
        r_d.cmd_v        = accept;
        r_d.cmd_d        = accept ? dout_wdata : r_q.cmd_d;
        r_d.clr          = wres.full_reset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stat_rdata = r_q.stat;
    assign irq        = r_q.stat[B_IRQ];
    assign cmd_valid  = r_q.cmd_v;
    assign cmd_data   = r_q.cmd_d;
    assign ctl_clear  = r_q.clr;

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_we && (stat_rdata[B_RUN] || stat_rdata[B_ACT]))
        |=> (!cmd_valid && stat_rdata[B_ERR]));

    // R10
    idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_we && !stat_rdata[B_RUN] && !stat_rdata[B_ACT])
        |=> (cmd_valid && stat_rdata[B_ACT] && cmd_data == $past(dout_wdata)));

    // R5
    reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[W_SET] && ctl_wdata[W_CLR]) |=> ctl_clear);

    // R6
    pi_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (stat_rdata[PI_W-1:0] == $past(ctl_wdata[PI_W-1:0])));

    // R11
    halt_run_chk: assert property (@(posedge clk) disable iff (rst)
        halt_evt |=> !stat_rdata[B_RUN]);

    // R11
    attn_set_chk: assert property (@(posedge clk) disable iff (rst)
        attn_evt |=> stat_rdata[B_ATTN]);

    // R7
    idle_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[B_IDLE_EN] && !stat_rdata[B_RUN]) |-> irq);

    // R3
    seekrq_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[W_CLR] && !ctl_wdata[W_SET])
        |=> (stat_rdata[B_SEEKRQ] == $past(stat_rdata[B_SEEKRQ])));

endmodule

// File: tb/chan_csr_test.sv
module chan_csr_test;

    localparam int ERR_W = 12;
    localparam int CMD_W = 36;

    logic              clk = 1'b0;
    logic              rst;
    logic              ctl_we;
    logic [17:0]       ctl_wdata;
    logic [17:0]       stat_rdata;
    logic [ERR_W-1:0]  err_word;
    logic              irq;
    logic              dout_we;
    logic [CMD_W-1:0]  dout_wdata;
    logic              cmd_valid;
    logic [CMD_W-1:0]  cmd_data;
    logic              ctl_clear;
    logic              chan_busy;
    logic              halt_evt;
    logic              attn_evt;
    logic              err_evt;
    logic [ERR_W-1:0]  err_code;

    int n_chk  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [17:0]      m_st;
    logic [ERR_W-1:0] m_err;
    logic             m_cv;
    logic [CMD_W-1:0] m_cd;
    logic             m_clr;

    always #5 clk = ~clk;

    chan_csr #(.ERR_W(ERR_W), .CMD_W(CMD_W), .BUSY_ERR_BIT(2)) uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .stat_rdata(stat_rdata), .err_word(err_word), .irq(irq),
        .dout_we(dout_we), .dout_wdata(dout_wdata), .cmd_valid(cmd_valid),
        .cmd_data(cmd_data), .ctl_clear(ctl_clear), .chan_busy(chan_busy),
        .halt_evt(halt_evt), .attn_evt(attn_evt), .err_evt(err_evt),
        .err_code(err_code)
    );

    function automatic logic irq_of(input logic [17:0] s);
        return (s[12] & s[11]) | (s[10] & s[9]) | (s[8] & ~s[7]);
    endfunction

    // next model state from the requirements
    task automatic model_step();
        logic [17:0]      st;
        logic [ERR_W-1:0] er;
        logic             bsy, acc, rej, full;
        st   = m_st;
        er   = m_err;
        bsy  = st[7] | st[6];
        acc  = dout_we & ~bsy;
        rej  = dout_we & bsy;
        full = ctl_we & ctl_wdata[17] & ctl_wdata[16];
        if (ctl_we) begin
            if (full) begin
                st = '0;
                er = '0;
            end
            if (ctl_wdata[17]) begin
                st = st | (ctl_wdata & 18'h01D80);
                if (ctl_wdata[9]) st[16] = 1'b1;
            end else if (ctl_wdata[16]) begin
                st = st & ~(ctl_wdata & 18'h01F80);
                if (ctl_wdata[11]) er = '0;
            end
            st[2:0] = ctl_wdata[2:0];
        end
        st[6] = acc | (~full & chan_busy & ~halt_evt);
        if (halt_evt) st[7] = 1'b0;
        if (attn_evt) st[9] = 1'b1;
        if (err_evt) begin
            er = er | err_code;
            st[11] = 1'b1;
        end
        if (rej) begin
            er[2] = 1'b1;
            st[11] = 1'b1;
        end
        st[17] = irq_of(st);
        m_st  = st;
        m_err = er;
        m_cv  = acc;
        if (acc) m_cd = dout_wdata;
        m_clr = full;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic cmp(input string tag);
        chk(tag, "status", 64'(stat_rdata), 64'(m_st));
        chk(tag, "irq", 64'(irq), 64'(m_st[17]));
        chk(tag, "errword", 64'(err_word), 64'(m_err));
        chk(tag, "cmd_valid", 64'(cmd_valid), 64'(m_cv));
        chk(tag, "cmd_data", 64'(cmd_data), 64'(m_cd));
        chk(tag, "ctl_clear", 64'(ctl_clear), 64'(m_clr));
    endtask

    task automatic step(input logic we, input logic [17:0] wd,
                        input logic dv, input logic [CMD_W-1:0] dd,
                        input logic hlt, input logic att,
                        input logic ev, input logic [ERR_W-1:0] code,
                        input logic bsy);
        @(negedge clk);
        ctl_we = we; ctl_wdata = wd; dout_we = dv; dout_wdata = dd;
        halt_evt = hlt; attn_evt = att; err_evt = ev; err_code = code;
        chan_busy = bsy;
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_step();
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        ctl_we = 0; ctl_wdata = '0; dout_we = 0; dout_wdata = '0;
        halt_evt = 0; attn_evt = 0; err_evt = 0; err_code = '0; chan_busy = 0;
        m_st = '0; m_err = '0; m_cv = 0; m_cd = '0; m_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp("R1");

        // R2 set: enables, error, run, seek request via bit 9, pi=5
        step(1'b1, 18'h21F85, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R2");
        cmp("R7");
        // R3 clear run -> idle interrupt path
        step(1'b1, 18'h10080, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R3");
        // R8 error event
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 12'h0F0, 1'b0);
        cmp("R8");
        // R4 clear with bit 11 wipes error word
        step(1'b1, 18'h10800, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R4");
        // R9 data-out while running
        step(1'b1, 18'h20080, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1, 36'h123456789, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R9");
        // R10 accepted when idle, then second rejected because active
        step(1'b1, 18'h10880, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1, 36'hABCDE0123, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R10");
        step(1'b0, '0, 1'b1, 36'h000000777, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R9");
        // R12 active follows busy, halt overrides
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        cmp("R12");
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0, '0, 1'b1);
        cmp("R12");
        // R11 set run with halt; clear attention with attention event
        step(1'b1, 18'h20480, 1'b0, '0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
        cmp("R11");
        step(1'b1, 18'h10200, 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
        cmp("R11");
        // R5 reset then set
        step(1'b1, 18'h30503, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R5");
        idle_step();
        cmp("R5");
        // R6 write with neither select bit
        step(1'b1, 18'h01F87, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cmp("R6");

        for (int i = 0; i < 4000; i++) begin
            logic [17:0] wd;
            wd = 18'($urandom);
            step(($urandom % 2) == 0, wd,
                 ($urandom % 5) == 0, {4'($urandom), 32'($urandom)},
                 ($urandom % 10) == 0, ($urandom % 8) == 0,
                 ($urandom % 9) == 0, 12'($urandom),
                 ($urandom % 3) == 0);
            cmp("R2 R3 R7 R11 R12 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule